// File: doc/BRIEF.md
# Digit Sequencer with Nibble Match Flag

This block combines a free-running eight-state sequencer, an 8-bit operand register and a nibble comparator. On every rising clock edge the sequencer moves to its next state. Each state presents one 4-bit digit, and the digit pattern 2, 6, 0, 8 appears twice per full lap of the eight states.

The operand register captures a byte when its load enable is high and keeps that byte otherwise. It has its own synchronous clear, separate from the sequencer reset.

A single option bit reports whether the high nibble or the low nibble of the stored byte equals the digit currently shown. Downstream logic can use this bit to choose between two computations that depend on the sequencer position.

Top module: `digit_match_ctrl`

## Requirements
- R1: While `seq_rst` is high at a rising edge, the sequencer goes to its first state, whose digit is 2. The reset is synchronous.
- R2: With `seq_rst` low, the sequencer advances one state per rising edge. The `digit` output is unsigned binary and follows the repeating order 2, 6, 0, 8.
- R3: The sequencer has eight states. States 0 to 3 show 2, 6, 0, 8, states 4 to 7 show 2, 6, 0, 8 again, and state 7 wraps to state 0.
- R4: When `ld_en` is high and `reg_rst` is low at a rising edge, `held` takes the value of `ld_data`.
- R5: When `ld_en` and `reg_rst` are both low, `held` keeps its value whatever `ld_data` carries.
- R6: `reg_rst` high at a rising edge clears `held` to 0x00. It overrides `ld_en` and does not affect the sequencer.
- R7: `option` is 1 exactly when `held[7:4]` or `held[3:0]` equals `digit`. It is combinational and follows changes in either input within the same cycle.
- R8: When both nibbles match the digit, `option` is still a single 1.
- R9: While `held` is 0x00, `option` is 1 only in states whose digit is 0, which is two states out of every eight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| seq_rst | input | 1 | Synchronous active-high sequencer reset |
| reg_rst | input | 1 | Synchronous active-high register clear |
| ld_en | input | 1 | Register load enable |
| ld_data | input | 8 | Byte to load |
| digit | output | 4 | Current sequencer digit |
| held | output | 8 | Stored operand |
| option | output | 1 | Nibble match flag |

## Verification
The bench checks for a match on the high nibble alone, on the low nibble alone, and on both at once. A comparator that looked at only one half would miss one of the first two cases, and one that added the two results would give a wrong value when both match. It also asserts clear and load in the same cycle: a design with the wrong priority would keep 0xFF instead of clearing.

The bench watches the wrap from state 7 back to state 0 and a sequencer reset in the middle of a lap. A counter of the wrong width would either stop cycling or show digits outside the pattern. Last, it holds the register at zero for a full lap and expects exactly two flagged cycles; a stale or registered flag would put them in the wrong place.

// File: rtl/digit_match_ctrl.sv
module digit_match_ctrl #(
  parameter int DATA_W = 8,
  parameter int NIB_W  = 4
) (
  input  logic              clk,
  input  logic              seq_rst,
  input  logic              reg_rst,
  input  logic              ld_en,
  input  logic [DATA_W-1:0] ld_data,
  output logic [NIB_W-1:0]  digit,
  output logic [DATA_W-1:0] held,
  output logic              option
);

  typedef enum logic [2:0] {
    ST0, ST1, ST2, ST3, ST4, ST5, ST6, ST7
  } seq_state_t;

  seq_state_t state, state_nx;

  always_comb begin
    case (state)
      ST0: state_nx = ST1;
      ST1: state_nx = ST2;
      ST2: state_nx = ST3;
      ST3: state_nx = ST4;
      ST4: state_nx = ST5;
      ST5: state_nx = ST6;
      ST6: state_nx = ST7;
      default: state_nx = ST0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (seq_rst) state <= ST0;
    else         state <= state_nx;
  end

  always_comb begin
    case (state)
      ST0, ST4: digit = NIB_W'(2);
      ST1, ST5: digit = NIB_W'(6);
      ST2, ST6: digit = NIB_W'(0);
      default:  digit = NIB_W'(8);
    endcase
  end

  always_ff @(posedge clk) begin
    if (reg_rst)    held <= '0;
    else if (ld_en) held <= ld_data;
  end

  assign option = (held[DATA_W-1 -: NIB_W] == digit) || (held[NIB_W-1:0] == digit);

endmodule

// File: rtl/digit_match_ctrl_chk.sv
module digit_match_ctrl_chk (
  input logic       clk,
  input logic       seq_rst,
  input logic       reg_rst,
  input logic       ld_en,
  input logic [7:0] ld_data,
  input logic [3:0] digit,
  input logic [7:0] held,
  input logic       option
);

  AST_SEQ_RESET: assert property (@(posedge clk) seq_rst |=> digit == 4'd2); // R1
  AST_STEP_2_6: assert property (@(posedge clk) disable iff (seq_rst) (!seq_rst && digit == 4'd2) |=> digit == 4'd6); // R2
  AST_STEP_6_0: assert property (@(posedge clk) disable iff (seq_rst) (!seq_rst && digit == 4'd6) |=> digit == 4'd0); // R2
  AST_STEP_0_8: assert property (@(posedge clk) disable iff (seq_rst) (!seq_rst && digit == 4'd0) |=> digit == 4'd8); // R3
  AST_STEP_8_2: assert property (@(posedge clk) disable iff (seq_rst) (!seq_rst && digit == 4'd8) |=> digit == 4'd2); // R3
  AST_LOAD: assert property (@(posedge clk) (ld_en && !reg_rst) |=> held == $past(ld_data)); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (reg_rst) (!ld_en && !reg_rst && !$isunknown(held)) |=> $stable(held)); // R5
  AST_CLEAR: assert property (@(posedge clk) reg_rst |=> held == 8'h00); // R6
  AST_FLAG: assert property (@(posedge clk) disable iff (seq_rst || reg_rst)
    !$isunknown(held) |-> option == ((held[7:4] == digit) || (held[3:0] == digit))); // R7
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (seq_rst || reg_rst)
    (held == 8'h00) |-> option == (digit == 4'd0)); // R9

endmodule

bind digit_match_ctrl digit_match_ctrl_chk chk_i (
  .clk(clk), .seq_rst(seq_rst), .reg_rst(reg_rst), .ld_en(ld_en),
  .ld_data(ld_data), .digit(digit), .held(held), .option(option)
);

// File: tb/digit_match_ctrl_tb_top.sv
module digit_match_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       seq_rst, reg_rst, ld_en;
  logic [7:0] ld_data;
  logic [3:0] digit;
  logic [7:0] held;
  logic       option;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  digit_match_ctrl dut_i (
    .clk(clk), .seq_rst(seq_rst), .reg_rst(reg_rst), .ld_en(ld_en),
    .ld_data(ld_data), .digit(digit), .held(held), .option(option)
  );

  // {seq_rst, reg_rst, ld_en, ld_data, exp digit, exp held, exp option}
  localparam logic [23:0] VEC [14] = '{
    {1'b0,1'b0,1'b1,8'h26,4'd6,8'h26,1'b1},
    {1'b0,1'b0,1'b0,8'h55,4'd0,8'h26,1'b0},
    {1'b0,1'b0,1'b1,8'h80,4'd8,8'h80,1'b1},
    {1'b0,1'b0,1'b1,8'h22,4'd2,8'h22,1'b1},
    {1'b0,1'b0,1'b0,8'hC3,4'd6,8'h22,1'b0},
    {1'b0,1'b1,1'b1,8'hFF,4'd0,8'h00,1'b1},
    {1'b0,1'b0,1'b0,8'h00,4'd8,8'h00,1'b0},
    {1'b0,1'b0,1'b0,8'h00,4'd2,8'h00,1'b0},
    {1'b0,1'b0,1'b1,8'h9A,4'd6,8'h9A,1'b0},
    {1'b1,1'b0,1'b0,8'h11,4'd2,8'h9A,1'b0},
    {1'b0,1'b0,1'b1,8'h2F,4'd6,8'h2F,1'b0},
    {1'b0,1'b0,1'b1,8'hF6,4'd0,8'hF6,1'b0},
    {1'b1,1'b0,1'b1,8'h02,4'd2,8'h02,1'b1},
    {1'b0,1'b0,1'b1,8'h66,4'd6,8'h66,1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    seq_rst = 1'b1; reg_rst = 1'b1; ld_en = 1'b0; ld_data = 8'h00;
    step(); step();
    seq_rst = 1'b0; reg_rst = 1'b0;
    chk("R1 reset digit", 32'(digit), 32'd2);
    chk("R6 reset held", 32'(held), 32'h00);
    chk("R7 reset option", 32'(option), 32'd0);

    for (int i = 0; i < 14; i++) begin
      {seq_rst, reg_rst, ld_en, ld_data} = VEC[i][23:13];
      step();
      chk($sformatf("R2/R3 vec%0d digit", i), 32'(digit), 32'(VEC[i][12:9]));
      chk($sformatf("R4/R5/R6 vec%0d held", i), 32'(held), 32'(VEC[i][8:1]));
      chk($sformatf("R7/R8 vec%0d option", i), 32'(option), 32'(VEC[i][0]));
    end
    seq_rst = 1'b0; reg_rst = 1'b0; ld_en = 1'b0;

    // R5: data toggles with load disabled; held must not move
    for (int i = 0; i < 4; i++) begin
      ld_data = 8'(8'hA5 ^ (i * 8'h3C));
      step();
      chk("R5 hold", 32'(held), 32'h66);
    end

    // R3/R9: zero register over a full lap, with sequence restart
    seq_rst = 1'b1; reg_rst = 1'b1;
    step();
    seq_rst = 1'b0; reg_rst = 1'b0;
    begin
      int hits = 0;
      logic [3:0] pat [4] = '{4'd2, 4'd6, 4'd0, 4'd8};
      for (int s = 0; s < 8; s++) begin
        chk("R3 lap digit", 32'(digit), 32'(pat[s % 4]));
        chk("R9 zero flag", 32'(option), 32'(digit == 4'd0));
        if (option) hits++;
        step();
      end
      chk("R9 zero hits per lap", 32'(hits), 32'd2);
      chk("R3 wrap to first", 32'(digit), 32'd2);
    end

    // R8: both nibbles match in a digit-0 state
    step();
    ld_en = 1'b1; ld_data = 8'h00;
    step();
    ld_en = 1'b0;
    chk("R8 both match digit", 32'(digit), 32'd0);
    chk("R8 both match option", 32'(option), 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule